// File: doc/BRIEF.md
# Flash Command and Status Register Unit

This block is the register-mapped front end of a page-organised flash device. A host writes 16-bit words into a small register window. The window holds identity words, a page-buffer size word, three address words, a command word, an interrupt word and a write-protect status word. When the command word is written, the unit decodes it. Protection commands finish in the same cycle and change only the protect status. Transfer commands (read, spare read, program, spare program, erase) become a request to an external transfer engine. The request carries an operation code, a linear byte offset and a buffer choice. The unit then stays busy until that engine reports completion.

The byte offset is built from the block word, the page word and the buffer-select word. If the dual-die bit is set in the block word, the block is moved into the upper half of the array. The interrupt word is written only when a transfer completes, or at once for a reset or an unrecognised command. Words written below the data-buffer address window form a small boot area. An identity-read command written there places the identity words into that area.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, the interrupt word (0x48) reads 0x0000 and the protect word (0x49) reads 0x0002. `busy` and `req_valid` are low, and the boot words 0..2 read 0x0000.
- R2: With default parameters, word 0x40 reads 0x0035, word 0x41 reads 0x0024 and word 0x42 reads 0x0007. Word 0x43 reads the page-buffer size: 0x0400 when bits [7:4] of word 0x41 are below 2, and 0x0800 otherwise.
- R3: A write of 0x0090 to any address below 0x08 loads boot words 0, 1 and 2 with the values of words 0x40, 0x41 and 0x42. A write of any other value there changes nothing.
- R4: With `lock_cont`=0, a command write to word 0x47 replaces the protect word one cycle later. Code 0x0023 gives 0x0004, code 0x002A gives 0x0002 and code 0x002C gives 0x0001. No request is issued, `busy` stays low and the interrupt word is unchanged.
- R5: With `lock_cont`=1, the same three codes OR their flag (0x0004, 0x0002, 0x0001) into the existing protect word.
- R6: The transfer codes and their `req_op` values are: 0x0000→0 (read), 0x0013→1 (spare read), 0x0080→2 (program), 0x001A→3 (spare program) and 0x0094→4 (erase). One of these codes sets `busy` and raises `req_valid` for exactly one cycle after the write edge.
- R7: For the non-erase transfer codes, `req_offset` is `(B << 17) + ((P >> 2) << 11)`. P is word 0x45 and `req_buf` is bit 8 of word 0x46. B is bits [14:0] of word 0x44, plus 256 when bit 15 of word 0x44 is set.
- R8: For erase, `req_offset` is `B << 17` alone and `req_buf` is 0.
- R9: While busy, the interrupt word keeps its value. At the edge where `xfer_done` is high, it becomes 0x8000 ORed with 0x0080 (op 0 or 1), 0x0040 (op 2 or 3) or 0x0020 (op 4), and `busy` falls at that same edge.
- R10: While busy, command writes are ignored: the command word, the protect word, `req_valid` and `req_op` keep their values.
- R11: Code 0x0003 has no effect on the interrupt word, the protect word, `busy` or the request outputs.
- R12: Code 0x00F0 writes the interrupt word to 0x8010 one cycle later without a transfer. Any code not listed in R4, R6, R11 or here writes 0x8000.
- R13: A host write to word 0x48 stores its value. `xfer_done` while not busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_cont | input | 1 | 1: protect flags accumulate; 0: each protect command replaces the status |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Word address of the read |
| rd_data | output | 16 | Read data (combinational) |
| busy | output | 1 | A transfer is outstanding |
| req_valid | output | 1 | One-cycle transfer request pulse |
| req_op | output | 3 | Transfer operation code |
| req_offset | output | 32 | Linear byte offset into the array |
| req_buf | output | 1 | Page buffer chosen (0 or 1) |
| xfer_done | input | 1 | Transfer engine completion |

## Verification
The hardest state to reach is a command write that lands while a transfer is outstanding. The protect word must then visibly resist the change, so the bench first drives the protect word to a value the blocked command would alter, then holds `xfer_done` low while issuing it. The interrupt word is preloaded with a marker before every transfer. The marker's survival across the busy window is what shows that the interrupt word waits for completion. The offset arithmetic is swept over all five transfer codes, with block words on both sides of the dual-die bit, page words with low bits set and both buffer choices.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int WORD_W = 16;

  // command codes
  localparam logic [WORD_W-1:0] C_READ      = 16'h0000;
  localparam logic [WORD_W-1:0] C_READ_SP   = 16'h0013;
  localparam logic [WORD_W-1:0] C_PROG      = 16'h0080;
  localparam logic [WORD_W-1:0] C_PROG_SP   = 16'h001A;
  localparam logic [WORD_W-1:0] C_ERASE     = 16'h0094;
  localparam logic [WORD_W-1:0] C_RESET     = 16'h00F0;
  localparam logic [WORD_W-1:0] C_BUFRAM    = 16'h0003;
  localparam logic [WORD_W-1:0] C_UNLOCK    = 16'h0023;
  localparam logic [WORD_W-1:0] C_LOCK      = 16'h002A;
  localparam logic [WORD_W-1:0] C_LOCK_TGT  = 16'h002C;
  localparam logic [WORD_W-1:0] C_READ_ID   = 16'h0090;

  // register offsets from the register window base
  localparam int R_MFR    = 0;
  localparam int R_DEV    = 1;
  localparam int R_VER    = 2;
  localparam int R_BUFSZ  = 3;
  localparam int R_BLK    = 4;
  localparam int R_PAGE   = 5;
  localparam int R_BUFSEL = 6;
  localparam int R_CMD    = 7;
  localparam int R_INT    = 8;
  localparam int R_WP     = 9;

  // interrupt bit positions
  localparam int IB_MASTER = 15;
  localparam int IB_READ   = 7;
  localparam int IB_WRITE  = 6;
  localparam int IB_ERASE  = 5;
  localparam int IB_RESET  = 4;

  // protect status bit positions
  localparam int PB_TIGHT    = 0;
  localparam int PB_LOCKED   = 1;
  localparam int PB_UNLOCKED = 2;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_READ_SP = 3'd1,
    OP_PROG    = 3'd2,
    OP_PROG_SP = 3'd3,
    OP_ERASE   = 3'd4
  } xfer_op_e;

  typedef enum logic [2:0] {
    K_XFER,
    K_PROTECT,
    K_BUFRAM,
    K_RESET,
    K_OTHER
  } cmd_kind_e;

  function automatic logic [WORD_W-1:0] done_irq(xfer_op_e op);
    logic [WORD_W-1:0] v;
    v = '0;
    v[IB_MASTER] = 1'b1;
    case (op)
      OP_READ, OP_READ_SP: v[IB_READ]  = 1'b1;
      OP_PROG, OP_PROG_SP: v[IB_WRITE] = 1'b1;
      OP_ERASE:            v[IB_ERASE] = 1'b1;
      default:             v = v;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [WORD_W-1:0] code_i,
  output cmd_kind_e         kind_o,
  output xfer_op_e          op_o,
  output logic [WORD_W-1:0] flag_o
);

  always_comb begin
    kind_o = K_OTHER;
    op_o   = OP_READ;
    flag_o = '0;
    case (code_i)
      C_READ:     begin kind_o = K_XFER; op_o = OP_READ;    end
      C_READ_SP:  begin kind_o = K_XFER; op_o = OP_READ_SP; end
      C_PROG:     begin kind_o = K_XFER; op_o = OP_PROG;    end
      C_PROG_SP:  begin kind_o = K_XFER; op_o = OP_PROG_SP; end
      C_ERASE:    begin kind_o = K_XFER; op_o = OP_ERASE;   end
      C_UNLOCK:   begin kind_o = K_PROTECT; flag_o[PB_UNLOCKED] = 1'b1; end
      C_LOCK:     begin kind_o = K_PROTECT; flag_o[PB_LOCKED]   = 1'b1; end
      C_LOCK_TGT: begin kind_o = K_PROTECT; flag_o[PB_TIGHT]    = 1'b1; end
      C_BUFRAM:   kind_o = K_BUFRAM;
      C_RESET:    kind_o = K_RESET;
      default:    kind_o = K_OTHER;
    endcase
  end

endmodule

// File: rtl/fcmd_protect.sv
module fcmd_protect
  import flash_cmd_pkg::*;
(
  input  logic              accumulate_i,
  input  logic [WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0] flag_i,
  output logic [WORD_W-1:0] next_o
);

  function automatic logic [WORD_W-1:0] merge(logic acc, logic [WORD_W-1:0] cur,
                                              logic [WORD_W-1:0] flag);
    return acc ? (cur | flag) : flag;
  endfunction

  assign next_o = merge(accumulate_i, cur_i, flag_i);

endmodule

// File: rtl/fcmd_offset.sv
module fcmd_offset
  import flash_cmd_pkg::*;
#(
  parameter int OFF_W          = 32,
  parameter int DIE_BIT        = 15,
  parameter int HALF_BLOCKS    = 256,
  parameter int ERASE_SHIFT    = 17,
  parameter int PAGE_SHIFT     = 11,
  parameter int PAGE_FLD_SHIFT = 2
) (
  input  logic [WORD_W-1:0] blk_i,
  input  logic [WORD_W-1:0] page_i,
  input  logic              buf_bit_i,
  input  logic              erase_i,
  output logic [OFF_W-1:0]  offset_o,
  output logic              buf_o
);

  function automatic logic [OFF_W-1:0] block_number(logic [WORD_W-1:0] b);
    logic [WORD_W-1:0] low;
    logic              upper;
    low          = b;
    upper        = b[DIE_BIT];
    low[DIE_BIT] = 1'b0;
    return OFF_W'(low) + (upper ? OFF_W'(HALF_BLOCKS) : '0);
  endfunction

  function automatic logic [OFF_W-1:0] page_number(logic [WORD_W-1:0] p);
    return OFF_W'(p >> PAGE_FLD_SHIFT);
  endfunction

  logic [OFF_W-1:0] blk_part;
  logic [OFF_W-1:0] page_part;

  assign blk_part  = block_number(blk_i) << ERASE_SHIFT;
  assign page_part = erase_i ? '0 : (page_number(page_i) << PAGE_SHIFT);
  assign offset_o  = blk_part + page_part;
  assign buf_o     = erase_i ? 1'b0 : buf_bit_i;

endmodule

// File: rtl/flash_cmd_front.sv
module flash_cmd_front
  import flash_cmd_pkg::*;
#(
  parameter int                ADDR_W         = 8,
  parameter int                OFF_W          = 32,
  parameter logic [ADDR_W-1:0] DATA_BASE      = 8'h08,
  parameter logic [ADDR_W-1:0] REG_BASE       = 8'h40,
  parameter logic [15:0]       MFR_ID         = 16'h0035,
  parameter logic [15:0]       DEV_ID         = 16'h0024,
  parameter logic [15:0]       VER_ID         = 16'h0007,
  parameter int                DENS_SHIFT     = 4,
  parameter int                ERASE_SHIFT    = 17,
  parameter int                DIE_BIT        = 15,
  parameter int                PAGE_FLD_SHIFT = 2,
  parameter int                BUF_SEL_BIT    = 8,
  parameter logic [15:0]       WP_RESET       = 16'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_cont,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              busy,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [OFF_W-1:0]  req_offset,
  output logic              req_buf,
  input  logic              xfer_done
);

  localparam int DENSITY     = int'((DEV_ID >> DENS_SHIFT) & 16'h000F);
  localparam int ARRAY_LOG   = 24 + DENSITY;
  localparam int BLOCKS_LOG  = ARRAY_LOG - ERASE_SHIFT;
  localparam int HALF_BLOCKS = 1 << (BLOCKS_LOG - 1);
  localparam int PAGE_SHIFT  = (DENSITY < 2) ? 10 : 11;
  localparam logic [15:0] BUF_BYTES = 16'(1 << PAGE_SHIFT);
  localparam int BOOT_WORDS  = 3;

  localparam logic [ADDR_W-1:0] A_MFR    = REG_BASE + ADDR_W'(R_MFR);
  localparam logic [ADDR_W-1:0] A_DEV    = REG_BASE + ADDR_W'(R_DEV);
  localparam logic [ADDR_W-1:0] A_VER    = REG_BASE + ADDR_W'(R_VER);
  localparam logic [ADDR_W-1:0] A_BUFSZ  = REG_BASE + ADDR_W'(R_BUFSZ);
  localparam logic [ADDR_W-1:0] A_BLK    = REG_BASE + ADDR_W'(R_BLK);
  localparam logic [ADDR_W-1:0] A_PAGE   = REG_BASE + ADDR_W'(R_PAGE);
  localparam logic [ADDR_W-1:0] A_BUFSEL = REG_BASE + ADDR_W'(R_BUFSEL);
  localparam logic [ADDR_W-1:0] A_CMD    = REG_BASE + ADDR_W'(R_CMD);
  localparam logic [ADDR_W-1:0] A_INT    = REG_BASE + ADDR_W'(R_INT);
  localparam logic [ADDR_W-1:0] A_WP     = REG_BASE + ADDR_W'(R_WP);

  // register state
  logic [15:0] blk_q, page_q, bufsel_q, cmd_q, int_q, wp_q;
  logic [15:0] boot_q [BOOT_WORDS];
  logic        busy_q, req_valid_q, req_buf_q;
  xfer_op_e    req_op_q;
  logic [OFF_W-1:0] req_offset_q;

  // decode of the incoming word
  cmd_kind_e   dec_kind;
  xfer_op_e    dec_op;
  logic [15:0] dec_flag;
  logic [15:0] wp_next;
  logic [OFF_W-1:0] off_calc;
  logic        buf_calc;

  // named events
  logic wr_boot, wr_cmd, cmd_accept;
  logic xfer_fire, lock_fire, bufram_fire, reset_fire, other_fire;
  logic xfer_end, id_load;

  assign wr_boot     = wr_en && (wr_addr < DATA_BASE);
  assign id_load     = wr_boot && (wr_data == C_READ_ID);
  assign wr_cmd      = wr_en && (wr_addr == A_CMD);
  assign cmd_accept  = wr_cmd && !busy_q;
  assign xfer_fire   = cmd_accept && (dec_kind == K_XFER);
  assign lock_fire   = cmd_accept && (dec_kind == K_PROTECT);
  assign bufram_fire = cmd_accept && (dec_kind == K_BUFRAM);
  assign reset_fire  = cmd_accept && (dec_kind == K_RESET);
  assign other_fire  = cmd_accept && (dec_kind == K_OTHER);
  assign xfer_end    = busy_q && xfer_done;

  fcmd_decode u_decode (
    .code_i (wr_data),
    .kind_o (dec_kind),
    .op_o   (dec_op),
    .flag_o (dec_flag)
  );

  fcmd_protect u_protect (
    .accumulate_i (lock_cont),
    .cur_i        (wp_q),
    .flag_i       (dec_flag),
    .next_o       (wp_next)
  );

  fcmd_offset #(
    .OFF_W          (OFF_W),
    .DIE_BIT        (DIE_BIT),
    .HALF_BLOCKS    (HALF_BLOCKS),
    .ERASE_SHIFT    (ERASE_SHIFT),
    .PAGE_SHIFT     (PAGE_SHIFT),
    .PAGE_FLD_SHIFT (PAGE_FLD_SHIFT)
  ) u_offset (
    .blk_i     (blk_q),
    .page_i    (page_q),
    .buf_bit_i (bufsel_q[BUF_SEL_BIT]),
    .erase_i   (dec_op == OP_ERASE),
    .offset_o  (off_calc),
    .buf_o     (buf_calc)
  );

  // address registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q    <= '0;
      page_q   <= '0;
      bufsel_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_BLK)    blk_q    <= wr_data;
      if (wr_addr == A_PAGE)   page_q   <= wr_data;
      if (wr_addr == A_BUFSEL) bufsel_q <= wr_data;
    end
  end

  // boot area
  generate
    for (genvar g = 0; g < BOOT_WORDS; g++) begin : g_boot
      localparam logic [15:0] ID_VAL = (g == 0) ? MFR_ID : (g == 1) ? DEV_ID : VER_ID;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       boot_q[g] <= '0;
        else if (id_load) boot_q[g] <= ID_VAL;
      end
    end
  endgenerate

  // command word and protect status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      wp_q  <= WP_RESET;
    end else begin
      if (cmd_accept) cmd_q <= wr_data;
      if (lock_fire)  wp_q  <= wp_next;
    end
  end

  // interrupt word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0;
    end else if (xfer_end) begin
      int_q <= done_irq(req_op_q);
    end else if (reset_fire) begin
      int_q <= 16'((1 << IB_MASTER) | (1 << IB_RESET));
    end else if (other_fire) begin
      int_q <= 16'(1 << IB_MASTER);
    end else if (wr_en && wr_addr == A_INT) begin
      int_q <= wr_data;
    end
  end

  // transfer request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      req_valid_q  <= 1'b0;
      req_op_q     <= OP_READ;
      req_offset_q <= '0;
      req_buf_q    <= 1'b0;
    end else begin
      req_valid_q <= xfer_fire;
      if (xfer_fire) begin
        busy_q       <= 1'b1;
        req_op_q     <= dec_op;
        req_offset_q <= off_calc;
        req_buf_q    <= buf_calc;
      end else if (xfer_end) begin
        busy_q <= 1'b0;
      end
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(BOOT_WORDS)) begin
      for (int i = 0; i < BOOT_WORDS; i++)
        if (rd_addr == ADDR_W'(i)) rd_data = boot_q[i];
    end else begin
      case (rd_addr)
        A_MFR:    rd_data = MFR_ID;
        A_DEV:    rd_data = DEV_ID;
        A_VER:    rd_data = VER_ID;
        A_BUFSZ:  rd_data = BUF_BYTES;
        A_BLK:    rd_data = blk_q;
        A_PAGE:   rd_data = page_q;
        A_BUFSEL: rd_data = bufsel_q;
        A_CMD:    rd_data = cmd_q;
        A_INT:    rd_data = int_q;
        A_WP:     rd_data = wp_q;
        default:  rd_data = '0;
      endcase
    end
  end

  assign busy       = busy_q;
  assign req_valid  = req_valid_q;
  assign req_op     = req_op_q;
  assign req_offset = req_offset_q;
  assign req_buf    = req_buf_q;

endmodule

// File: rtl/flash_cmd_front_chk.sv
module flash_cmd_front_chk #(
  parameter int OFF_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [OFF_W-1:0] req_offset,
  input logic             xfer_done,
  input logic             lock_fire,
  input logic             bufram_fire,
  input logic [15:0]      int_q
);

  // R6: request is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R6: busy is raised together with the request
  a_r6_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req_valid);

  // R10: request fields hold while a transfer is outstanding
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> (busy && $stable(req_op) && $stable(req_offset) && !req_valid));

  // R9: completion releases busy on the same edge
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_done) |=> !busy);

  // R4: protect commands never touch the interrupt word or start a transfer
  a_r4_protect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    lock_fire |=> ($stable(int_q) && !req_valid));

  // R11: buffer-RAM command is inert
  a_r11_bufram_inert: assert property (@(posedge clk) disable iff (!rst_n)
    bufram_fire |=> ($stable(int_q) && !busy && !req_valid));

endmodule

bind flash_cmd_front flash_cmd_front_chk #(.OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_offset  (req_offset),
  .xfer_done   (xfer_done),
  .lock_fire   (lock_fire),
  .bufram_fire (bufram_fire),
  .int_q       (int_q)
);

// File: tb/flash_cmd_front_bench.sv
module flash_cmd_front_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_cont = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, req_valid, req_buf;
  logic [2:0]  req_op;
  logic [31:0] req_offset;
  logic        xfer_done = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_front u_flash_cmd_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .lock_cont  (lock_cont),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_offset (req_offset),
    .req_buf    (req_buf),
    .xfer_done  (xfer_done)
  );

  localparam logic [7:0] A_MFR = 8'h40, A_DEV = 8'h41, A_VER = 8'h42, A_BSZ = 8'h43;
  localparam logic [7:0] A_BLK = 8'h44, A_PG = 8'h45, A_BSEL = 8'h46, A_CMD = 8'h47;
  localparam logic [7:0] A_INT = 8'h48, A_WP = 8'h49;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic done_pulse;
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  function automatic logic [31:0] exp_off(int op, logic [15:0] b, logic [15:0] p);
    longint bn, o;
    bn = longint'(b & 16'h7FFF) + (b[15] ? 256 : 0);
    o  = bn * 131072;
    if (op != 4) o = o + longint'(p / 4) * 2048;
    return o[31:0];
  endfunction

  function automatic logic [15:0] exp_irq(int op);
    if (op < 2) return 16'h8080;
    if (op < 4) return 16'h8040;
    return 16'h8020;
  endfunction

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] codes [5];
    logic [15:0] blks [6];
    logic [15:0] pgs [2];
    logic [15:0] bsels [2];
    codes = '{16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h0094};
    blks  = '{16'h0000, 16'h0001, 16'h0123, 16'h7FFF, 16'h8000, 16'h80FF};
    pgs   = '{16'h0000, 16'h00FD};
    bsels = '{16'h0000, 16'h0100};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_INT, v); chk("R1 int", v, 16'h0000);
    rd(A_WP, v);  chk("R1 wp", v, 16'h0002);
    chk("R1 busy", busy, 0);
    chk("R1 req_valid", req_valid, 0);
    for (int i = 0; i < 3; i++) begin rd(8'(i), v); chk("R1 boot", v, 0); end

    // R2 identity
    rd(A_MFR, v); chk("R2 mfr", v, 16'h0035);
    rd(A_DEV, v); chk("R2 dev", v, 16'h0024);
    rd(A_VER, v); chk("R2 ver", v, 16'h0007);
    rd(A_BSZ, v); chk("R2 bufsz", v, 16'h0800);

    // R3 boot area
    wr(8'h02, 16'h0055);
    for (int i = 0; i < 3; i++) begin rd(8'(i), v); chk("R3 boot other", v, 0); end
    wr(8'h05, 16'h0090);
    rd(8'h00, v); chk("R3 boot0", v, 16'h0035);
    rd(8'h01, v); chk("R3 boot1", v, 16'h0024);
    rd(8'h02, v); chk("R3 boot2", v, 16'h0007);

    // R4 replace mode
    lock_cont = 1'b0;
    wr(A_CMD, 16'h0023); rd(A_WP, v); chk("R4 unlock", v, 16'h0004);
    chk("R4 busy", busy, 0); chk("R4 req", req_valid, 0);
    wr(A_CMD, 16'h002C); rd(A_WP, v); chk("R4 tight", v, 16'h0001);
    wr(A_CMD, 16'h002A); rd(A_WP, v); chk("R4 lock", v, 16'h0002);
    rd(A_INT, v); chk("R4 int", v, 16'h0000);

    // R5 accumulate mode
    lock_cont = 1'b1;
    wr(A_CMD, 16'h0023); rd(A_WP, v); chk("R5 unlock", v, 16'h0006);
    wr(A_CMD, 16'h002C); rd(A_WP, v); chk("R5 tight", v, 16'h0007);

    // R6 R7 R8 R9 sweep
    for (int oi = 0; oi < 5; oi++)
      for (int bi = 0; bi < 6; bi++)
        for (int pi = 0; pi < 2; pi++)
          for (int si = 0; si < 2; si++) begin
            wr(A_BLK, blks[bi]);
            wr(A_PG, pgs[pi]);
            wr(A_BSEL, bsels[si]);
            wr(A_INT, 16'hAAAA);
            wr(A_CMD, codes[oi]);
            chk("R6 req_valid", req_valid, 1);
            chk("R6 busy", busy, 1);
            chk("R6 op", req_op, oi);
            chk(oi == 4 ? "R8 offset" : "R7 offset", req_offset, exp_off(oi, blks[bi], pgs[pi]));
            chk(oi == 4 ? "R8 buf" : "R7 buf", req_buf, (oi == 4) ? 0 : bsels[si][8]);
            @(negedge clk);
            chk("R6 pulse", req_valid, 0);
            rd(A_INT, v); chk("R9 int held", v, 16'hAAAA);
            done_pulse();
            chk("R9 busy clear", busy, 0);
            rd(A_INT, v); chk("R9 int", v, exp_irq(oi));
          end

    // R10 commands while busy
    lock_cont = 1'b0;
    wr(A_CMD, 16'h0080);
    @(negedge clk);
    wr(A_CMD, 16'h002A);
    rd(A_WP, v);  chk("R10 wp", v, 16'h0007);
    rd(A_CMD, v); chk("R10 cmd", v, 16'h0080);
    wr(A_CMD, 16'h0094);
    chk("R10 req_valid", req_valid, 0);
    chk("R10 op", req_op, 2);
    chk("R10 busy", busy, 1);
    done_pulse();
    rd(A_INT, v); chk("R10 int after", v, 16'h8040);

    // R11 buffer-RAM
    wr(A_INT, 16'h1234);
    wr(A_CMD, 16'h0003);
    chk("R11 busy", busy, 0); chk("R11 req", req_valid, 0);
    rd(A_INT, v); chk("R11 int", v, 16'h1234);
    rd(A_WP, v);  chk("R11 wp", v, 16'h0007);

    // R12 reset and unknown
    wr(A_CMD, 16'h00F0);
    rd(A_INT, v); chk("R12 reset", v, 16'h8010);
    chk("R12 busy", busy, 0);
    wr(A_CMD, 16'h0055);
    rd(A_INT, v); chk("R12 other", v, 16'h8000);

    // R13 host write and stray done
    wr(A_INT, 16'h0101);
    rd(A_INT, v); chk("R13 host write", v, 16'h0101);
    done_pulse();
    rd(A_INT, v); chk("R13 stray done", v, 16'h0101);
    chk("R13 busy", busy, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule